// File: doc/BRIEF.md
# Card Socket Insertion and Power Sequencer

This block is the host-side controller for one removable 16-bit card socket. It filters the two card-detect inputs. When a card is seated, it reads the two voltage-sense pins once and decides whether the card's power-up voltage can be served. If it can, the block turns on the matching supply rail. The card-facing bus drivers and reset stay isolated for a settling interval, then the interface is enabled and the block waits for the card to report ready.

Software can ask for a different supply level. The block then always drops power first and waits for the rail to discharge before it turns on the new rail. Pulling the card out forces the socket cold. Sticky event bits report insertion, removal and initialization failure, and together they drive one interrupt line.

Top module: `card_socket_seq`

## Requirements
- R1: Out of reset, and whenever no card is present, both supply enables and `if_en` are 0.
- R2: A card counts as present (`st_present`=1) only after both `cd_n` bits have been low for DEB_CYC consecutive clocks. A shorter low pulse, or only one bit low, leaves it absent. Power turns on DEB_CYC+2 clocks after both bits go low.
- R3: At insertion, `vs1_n`=0 selects 3.3 V (`en_3v3`=1, `st_volt`=0) and `vs1_n`=1 selects 5 V (`en_5v`=1, `st_volt`=1). The sense pins are read only at that point, so later changes on them have no effect.
- R4: If `vs2_n`=0 at insertion, no rail is enabled and `st_reject`=1. The socket stays unpowered until the card is removed.
- R5: `if_en` rises exactly SETTLE_CYC clocks after a supply enable rises, and it is never 1 while both enables are 0.
- R6: If `ready` is still low READY_CYC clocks after `if_en` rose, the block drops power and interface and sets the fail event. It stays unpowered until the card is removed. If `ready` is high, the socket stays enabled.
- R7: A `vchg_req` pulse while enabled that names the other voltage (`vchg_5v`: 1 = 5 V) turns the socket off, then powers it at the new level and settles again. A request that names the present level is ignored.
- R8: `en_3v3` and `en_5v` are never both 1, and a rail never follows the other rail without an all-off clock between them.
- R9: One clock after `st_present` falls, both enables and `if_en` are 0, and the remove event is set.
- R10: `ev_flags` bit 0 = insert, bit 1 = remove, bit 2 = init fail. The bits are sticky. A 1 in the matching `ev_clr` bit clears one, and `irq` is 1 while any bit is set.
- R11: After a shutdown, power returns only after `discharge_done` is seen or after DISCH_CYC clocks, whichever comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cd_n | input | 2 | Card-detect pins, low when seated |
| vs1_n | input | 1 | Voltage sense 1, low = 3.3 V card |
| vs2_n | input | 1 | Voltage sense 2, low = unsupported voltage |
| ready | input | 1 | Card ready indication |
| discharge_done | input | 1 | Rail reached zero volts |
| vchg_req | input | 1 | Voltage change request pulse |
| vchg_5v | input | 1 | Requested level: 1 = 5 V, 0 = 3.3 V |
| ev_clr | input | 3 | Write-one-to-clear for event bits |
| en_3v3 | output | 1 | Enable for the 3.3 V switch |
| en_5v | output | 1 | Enable for the 5 V switch |
| if_en | output | 1 | Enables bus drivers and reset toward the card |
| st_present | output | 1 | Debounced card presence |
| st_volt | output | 1 | Selected voltage, 1 = 5 V |
| st_reject | output | 1 | Card voltage unsupported |
| ev_flags | output | 3 | Sticky events {fail, remove, insert} |
| irq | output | 1 | Any event pending |

## Verification
The checker watches the safety rules on every clock: the two rails are never both on and never switch directly, the interface is never enabled without power, a rejected card is never powered, power and interface go off one clock after presence is lost, and a new insertion raises the interrupt. Some behaviour depends on time or on history, and only the bench scenarios can show it. This covers the exact debounce, settle, ready-timeout and discharge intervals, the one-time sampling of the sense pins, the ignoring of a same-level request, and the sticky clearing of events.

// File: rtl/card_socket_seq.sv
module card_socket_seq #(
  parameter int DEB_CYC    = 25000,
  parameter int SETTLE_CYC = 25000000,
  parameter int READY_CYC  = 1250000000,
  parameter int DISCH_CYC  = 2500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cd_n,
  input  logic       vs1_n,
  input  logic       vs2_n,
  input  logic       ready,
  input  logic       discharge_done,
  input  logic       vchg_req,
  input  logic       vchg_5v,
  input  logic [2:0] ev_clr,
  output logic       en_3v3,
  output logic       en_5v,
  output logic       if_en,
  output logic       st_present,
  output logic       st_volt,
  output logic       st_reject,
  output logic [2:0] ev_flags,
  output logic       irq
);
  localparam int TMAX = (SETTLE_CYC > READY_CYC)
                        ? ((SETTLE_CYC > DISCH_CYC) ? SETTLE_CYC : DISCH_CYC)
                        : ((READY_CYC > DISCH_CYC) ? READY_CYC : DISCH_CYC);
  localparam int CW = $clog2(TMAX + 1);
  localparam int DW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] SET_LIM = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] RDY_LIM = CW'(READY_CYC - 1);
  localparam logic [CW-1:0] DIS_LIM = CW'(DISCH_CYC - 1);
  localparam logic [DW-1:0] DEB_LIM = DW'(DEB_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_SENSE, S_PWR, S_WAIT, S_ACT, S_DISCH, S_HOLD} st_t;

  st_t           state;
  logic [CW-1:0] tcnt;
  logic [DW-1:0] dcnt;
  logic          deb, deb_q, volt, chg, hold, rej;
  logic [2:0]    ev;
  logic          raw, ins, rem, fail_set, pwr;

  assign raw      = ~cd_n[0] & ~cd_n[1];
  assign ins      = deb & ~deb_q;
  assign rem      = ~deb & deb_q;
  assign fail_set = (state == S_WAIT) & deb & ~ready & (tcnt == RDY_LIM);
  assign pwr      = (state == S_PWR) | (state == S_WAIT) | (state == S_ACT);

  assign en_3v3     = pwr & ~volt;
  assign en_5v      = pwr & volt;
  assign if_en      = (state == S_WAIT) | (state == S_ACT);
  assign st_present = deb;
  assign st_volt    = volt;
  assign st_reject  = rej;
  assign ev_flags   = ev;
  assign irq        = |ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deb   <= 1'b0;
      deb_q <= 1'b0;
      dcnt  <= '0;
    end else begin
      deb_q <= deb;
      if (raw == deb) dcnt <= '0;
      else if (dcnt == DEB_LIM) begin
        deb  <= raw;
        dcnt <= '0;
      end else dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev <= '0;
    else        ev <= (ev & ~ev_clr) | {fail_set, rem, ins};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      tcnt  <= '0;
      volt  <= 1'b0;
      chg   <= 1'b0;
      hold  <= 1'b0;
      rej   <= 1'b0;
    end else begin
      tcnt <= tcnt + 1'b1;
      if (ins) rej <= 1'b0;
      case (state)
        S_IDLE:  if (deb) state <= S_SENSE;
        S_SENSE: begin
          if (!deb) state <= S_IDLE;
          else if (!vs2_n) begin
            state <= S_HOLD;
            rej   <= 1'b1;
          end else begin
            volt  <= vs1_n;
            state <= S_PWR;
            tcnt  <= '0;
          end
        end
        S_PWR: begin
          if (!deb) begin
            state <= S_DISCH;
            tcnt  <= '0;
          end else if (tcnt == SET_LIM) begin
            state <= S_WAIT;
            tcnt  <= '0;
          end
        end
        S_WAIT: begin
          if (!deb) begin
            state <= S_DISCH;
            tcnt  <= '0;
          end else if (ready) state <= S_ACT;
          else if (tcnt == RDY_LIM) begin
            hold  <= 1'b1;
            state <= S_DISCH;
            tcnt  <= '0;
          end
        end
        S_ACT: begin
          if (!deb) begin
            state <= S_DISCH;
            tcnt  <= '0;
          end else if (vchg_req && (vchg_5v != volt)) begin
            volt  <= vchg_5v;
            chg   <= 1'b1;
            state <= S_DISCH;
            tcnt  <= '0;
          end
        end
        S_DISCH: begin
          if (discharge_done || tcnt == DIS_LIM) begin
            chg  <= 1'b0;
            hold <= 1'b0;
            tcnt <= '0;
            if (deb && chg)       state <= S_PWR;
            else if (deb && hold) state <= S_HOLD;
            else                  state <= S_IDLE;
          end
        end
        S_HOLD:  if (!deb) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (rem) begin
        chg  <= 1'b0;
        hold <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/card_socket_seq_chk.sv
module card_socket_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic en_3v3,
  input logic en_5v,
  input logic if_en,
  input logic st_present,
  input logic st_reject,
  input logic irq
);
  // R8
  rails_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_3v3 && en_5v));
  // R8
  no_direct_3to5_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_3v3 |=> !en_5v);
  // R8
  no_direct_5to3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_5v |=> !en_3v3);
  // R5
  bus_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_en |-> (en_3v3 || en_5v));
  // R5
  bus_off_at_power_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_3v3) || $rose(en_5v)) |-> !if_en);
  // R4
  reject_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_reject |-> (!en_3v3 && !en_5v));
  // R9
  removal_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_present) |=> (!en_3v3 && !en_5v && !if_en));
  // R1
  absent_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_present && $past(!st_present)) |-> (!en_3v3 && !en_5v && !if_en));
  // R10
  insert_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_present) |=> irq);
endmodule

bind card_socket_seq card_socket_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en_3v3(en_3v3), .en_5v(en_5v), .if_en(if_en),
  .st_present(st_present), .st_reject(st_reject), .irq(irq)
);

// File: tb/test_card_socket_seq.sv
module test_card_socket_seq;
  localparam int DEB = 4, SET = 20, RDY = 50, DIS = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cd_n = 2'b11;
  logic vs1_n = 1'b1, vs2_n = 1'b1, ready = 1'b0, discharge_done = 1'b0;
  logic vchg_req = 1'b0, vchg_5v = 1'b0;
  logic [2:0] ev_clr = 3'b000;
  logic en_3v3, en_5v, if_en, st_present, st_volt, st_reject, irq;
  logic [2:0] ev_flags;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  card_socket_seq #(.DEB_CYC(DEB), .SETTLE_CYC(SET), .READY_CYC(RDY), .DISCH_CYC(DIS))
    i_card_socket_seq (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [1:0] exp_rails(input logic v1, input logic v2);
    if (!v2) return 2'b00;
    return v1 ? 2'b10 : 2'b01;
  endfunction

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pwr(output int n);
    n = 0;
    while (!(en_3v3 || en_5v) && n < 1000) begin tick(); n++; end
  endtask

  task automatic wait_if(input logic lvl, output int n);
    n = 0;
    while (if_en != lvl && n < 1000) begin tick(); n++; end
  endtask

  task automatic clear_ev();
    ev_clr = 3'b111; tick(); ev_clr = 3'b000;
  endtask

  task automatic pull_card();
    cd_n = 2'b11; tick(DEB + DIS + 6); clear_ev(); tick();
  endtask

  task automatic req_volt(input logic v5);
    vchg_req = 1'b1; vchg_5v = v5; tick(); vchg_req = 1'b0;
  endtask

  initial begin
    int n;
    tick(3); rst_n = 1'b1; tick();
    chk("R1 reset rails", {en_5v, en_3v3}, 0);
    chk("R1 reset if_en", if_en, 0);
    chk("R10 reset irq", irq, 0);

    cd_n = 2'b00; tick(DEB - 1); cd_n = 2'b11; tick(10);
    chk("R2 short glitch present", st_present, 0);
    chk("R2 short glitch rails", {en_5v, en_3v3}, 0);
    cd_n = 2'b10; tick(20);
    chk("R2 one pin present", st_present, 0);
    cd_n = 2'b11; tick(2);

    vs1_n = 1'b0; vs2_n = 1'b1; ready = 1'b0;
    cd_n = 2'b00; wait_pwr(n);
    chk("R2 insertion latency", n, DEB + 2);
    chk("R3 3v3 rails", {en_5v, en_3v3}, 1);
    chk("R3 3v3 st_volt", st_volt, 0);
    chk("R5 isolated at power-up", if_en, 0);
    chk("R10 insert event", ev_flags, 3'b001);
    chk("R10 irq", irq, 1);
    wait_if(1'b1, n);
    chk("R5 settle interval", n, SET);
    ready = 1'b1; tick(3);
    chk("R6 ready keeps interface", if_en, 1);
    vs1_n = 1'b1; vs2_n = 1'b0; tick(10);
    chk("R3 no re-sense rails", {en_5v, en_3v3}, 1);
    chk("R3 no re-sense reject", st_reject, 0);
    vs1_n = 1'b0; vs2_n = 1'b1;
    clear_ev(); tick();
    chk("R10 cleared irq", irq, 0);

    req_volt(1'b0); tick(5);
    chk("R7 same level ignored", {en_5v, en_3v3, if_en}, 3'b011);

    req_volt(1'b1);
    chk("R7 change drops power", {en_5v, en_3v3, if_en}, 0);
    tick(10);
    chk("R11 wait for discharge", {en_5v, en_3v3}, 0);
    discharge_done = 1'b1; tick(); discharge_done = 1'b0;
    chk("R7 new rail", {en_5v, en_3v3}, 2);
    chk("R7 new st_volt", st_volt, 1);
    wait_if(1'b1, n);
    chk("R7 settle again", n, SET);

    cd_n = 2'b11; n = 0;
    while ((en_3v3 || en_5v) && n < 1000) begin tick(); n++; end
    chk("R9 removal latency", n, DEB + 1);
    chk("R9 interface off", if_en, 0);
    chk("R10 remove event", ev_flags, 3'b010);
    tick(DIS + 5); clear_ev(); tick();

    vs1_n = 1'b0; vs2_n = 1'b0; cd_n = 2'b00; tick(DEB + 30);
    chk("R4 reject flag", st_reject, 1);
    chk("R4 no power", {en_5v, en_3v3, if_en}, 0);
    chk("R4 still present", st_present, 1);
    pull_card();

    vs1_n = 1'b1; vs2_n = 1'b1; ready = 1'b0; cd_n = 2'b00; wait_pwr(n);
    chk("R3 5v rails", {en_5v, en_3v3}, 2);
    wait_if(1'b1, n);
    wait_if(1'b0, n);
    chk("R6 ready timeout", n, RDY);
    chk("R6 power off", {en_5v, en_3v3}, 0);
    chk("R10 fail event", ev_flags[2], 1);
    tick(DIS + 20);
    chk("R6 hold until removal", {en_5v, en_3v3, if_en}, 0);
    pull_card();

    vs1_n = 1'b0; ready = 1'b1; cd_n = 2'b00; wait_pwr(n); wait_if(1'b1, n); tick(2);
    req_volt(1'b1);
    n = 0;
    while (!en_5v && n < 1000) begin tick(); n++; end
    chk("R11 discharge timeout", n, DIS);
    pull_card();

    for (int it = 0; it < 24; it++) begin
      logic v1, v2;
      logic [1:0] e;
      int g;
      v1 = 1'($urandom); v2 = 1'($urandom); g = 1 + ($urandom % (DEB - 1));
      e = exp_rails(v1, v2);
      vs1_n = v1; vs2_n = v2; ready = 1'b1;
      cd_n = 2'b00; tick(g); cd_n = 2'b11; tick(1 + ($urandom % 3));
      cd_n = 2'b00; tick(DEB + 2);
      chk("R3 random rails", {en_5v, en_3v3}, e);
      chk("R4 random reject", st_reject, !v2);
      tick(SET + 2);
      chk("R5 random interface", if_en, v2);
      pull_card();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule